// File: doc/BRIEF.md
# External Interrupt Polarity Conditioner

This block sits between three external interrupt pins and a parent interrupt controller that understands only active-high levels and rising edges. Each pin has an 8-bit control field that holds its trigger type, an enable, a sampling-rate select and a pending flag. The block passes every pin through a synchroniser and flips its polarity where needed. A level request reaches the parent as an active-high level. An edge request reaches the parent as a one-cycle high pulse, and the edge stays recorded in a pending flag until software clears it.

Software reaches the control fields through a plain single-cycle register port. Writes take effect on the clock edge where `reg_wr` is high, and reads are combinational from `reg_addr`. A parameter picks one of two layouts. In the first, all three fields share one 32-bit word. In the second, each line has its own word. The port has no handshake: every write is accepted, and read data is valid in the same cycle.

Top module: `extirq_cond`

## Requirements
- R1: After reset every field reads zero: level type active-high, line disabled, sampling select 0, nothing pending, and every `irq_out` bit is low.
- R2: Field layout within a byte: trigger type in bits 7:6, enable in bit 5, sampling select in bit 4, bits 3:1 read as zero, and bit 0 is the pending/request flag.
- R3: With `SHARED`=1, word address 0 holds line 0 in bits 23:16, line 1 in bits 15:8 and line 2 in bits 7:0. Bits 31:24 read zero. Any other address reads zero and ignores writes.
- R4: With `SHARED`=1, a write changes only the fields whose byte lane has its bit of `reg_wstrb` set (lane n is bits 8n+7:8n).
- R5: With `SHARED`=0, line i lives in bits 7:0 of word address i, gated by strobe bit 0. Upper bits read zero, and addresses of 3 or more read zero and ignore writes.
- R6: Trigger type 00 is an active-high level and 01 is an active-low level. When the line is enabled, `irq_out` is high while the input is at its active level. With fast sampling, `irq_out` follows an input change two clock edges later. For these types, bit 0 reads the current request.
- R7: Trigger type 10 is a rising edge and 11 is a falling edge. With fast sampling, the pending flag sets three clock edges after the input makes the selected transition. `irq_out` is high for exactly that one cycle. The opposite transition does nothing.
- R8: For edge types, the pending flag stays set until a write puts a 1 in bit 0. Writing 0 there leaves it set.
- R9: With the enable at 0, `irq_out` stays low for that line and no edge sets its pending flag.
- R10: Sampling select 1 samples the input every clock. Sampling select 0 samples only once every `SLOW_DIV` clocks. A level change then appears no sooner than `SLOW_DIV`+1 edges and no later than 2*`SLOW_DIV` edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| irq_raw | input | NUM_LINES | Raw external interrupt pins, asynchronous |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | NUM_LINES | Conditioned requests to the parent controller |

## Verification
A register write is visible on `reg_rdata` as soon as the clock edge that performs it has passed. A level output changes two edges after its input moves. An edge sets the pending flag and pulses the output on the third edge, and the pulse is gone by the fourth. The bench drives all inputs on falling edges and counts rising edges from there. It samples just before the due edge, to see that nothing happens early, and again just after it, to see the new value. Slow sampling is checked at both ends of its window: still low after `SLOW_DIV` edges and high after 2*`SLOW_DIV` edges.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Trigger type field codes
  typedef enum logic [1:0] {
    TRIG_LVL_HIGH = 2'b00,
    TRIG_LVL_LOW  = 2'b01,
    TRIG_EDGE_UP  = 2'b10,
    TRIG_EDGE_DN  = 2'b11
  } trig_e;

  // Bit positions inside a line's control byte
  localparam int FLD_PEND  = 0;
  localparam int FLD_FAST  = 4;
  localparam int FLD_EN    = 5;
  localparam int FLD_TRIG  = 6;
  localparam int FLD_W     = 8;

  // Stored configuration of one line
  typedef struct packed {
    logic [1:0] trig;
    logic       en;
    logic       fast;
  } line_cfg_t;

endpackage

// File: rtl/extirq_tick.sv
module extirq_tick #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R10: slow sampling strobe never stays high on back-to-back cycles
  a_r10_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs #(
  parameter bit SHARED    = 1'b1,
  parameter int NUM_LINES = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  input  logic [3:0]             wstrb,
  input  logic [NUM_LINES*8-1:0] line_rd,
  output logic [NUM_LINES-1:0]   line_we,
  output logic [NUM_LINES*8-1:0] line_wbyte,
  output logic [31:0]            rdata
);
  logic unused_bus;
  assign unused_bus = ^{wdata, wstrb};

  generate
    if (SHARED) begin : g_shared
      logic hit;
      assign hit = (addr == '0);

      for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
        localparam int LANE = NUM_LINES - 1 - i;
        assign line_we[i] = wr & hit & wstrb[LANE];
        assign line_wbyte[i*8 +: 8] = wdata[LANE*8 +: 8];
      end

      always_comb begin
        rdata = '0;
        if (hit) begin
          for (int i = 0; i < NUM_LINES; i++)
            rdata[(NUM_LINES-1-i)*8 +: 8] = line_rd[i*8 +: 8];
        end
      end
    end else begin : g_split
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_word
        assign line_we[i] = wr & (addr == ADDR_W'(i)) & wstrb[0];
        assign line_wbyte[i*8 +: 8] = wdata[7:0];
      end

      always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_LINES; i++)
          if (addr == ADDR_W'(i)) rdata[7:0] = line_rd[i*8 +: 8];
      end
    end
  endgenerate

endmodule

// File: rtl/extirq_line.sv
module extirq_line
  import extirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       raw_in,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic [7:0] field_rd,
  output logic       irq_out
);
  line_cfg_t cfg;
  logic sync1, sync2, sync2_q;
  logic pend, pulse_q;
  logic adv, is_edge, evt, level_req;
  logic unused_wr;

  assign unused_wr = ^wr_byte[3:1];
  assign adv       = cfg.fast | slow_tick;
  assign is_edge   = cfg.trig[1];

  // Edge detection on the synchronised raw pin, so polarity changes
  // written by software never create a spurious event
  always_comb begin
    if (cfg.trig == TRIG_EDGE_DN) evt = sync2_q & ~sync2;
    else                          evt = sync2 & ~sync2_q;
    evt = evt & adv & is_edge & cfg.en;
  end

  assign level_req = cfg.en & ~is_edge & (sync2 ^ cfg.trig[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      sync2_q <= 1'b0;
      pend    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (adv) begin
        sync1   <= raw_in;
        sync2   <= sync1;
        sync2_q <= sync2;
      end
      if (wr_en) begin
        cfg.trig <= wr_byte[FLD_TRIG +: 2];
        cfg.en   <= wr_byte[FLD_EN];
        cfg.fast <= wr_byte[FLD_FAST];
      end
      pulse_q <= evt & ~pend;
      if (evt)                          pend <= 1'b1;
      else if (!is_edge)                pend <= 1'b0;
      else if (wr_en && wr_byte[FLD_PEND]) pend <= 1'b0;
    end
  end

  assign irq_out  = is_edge ? pulse_q : level_req;
  assign field_rd = {cfg.trig, cfg.en, cfg.fast, 3'b000, is_edge ? pend : level_req};

  // Cycles since reset, for checks that look two cycles back
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R6: enabled level line with fast sampling tracks the pin two edges late
  a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !is_edge && cfg.en && $stable(cfg) &&
     $past(cfg.fast) && $past(cfg.fast, 2))
      |-> (irq_out == ($past(raw_in, 2) ^ cfg.trig[0])));

  // R7: an edge request is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R8: pending survives unless a write-one-to-clear arrives
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && is_edge && !(wr_en && wr_byte[FLD_PEND])) |=> pend);

  // R9: pending can only rise while the line was enabled
  a_r9_masked_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(cfg.en));

endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
  import extirq_pkg::*;
#(
  parameter bit SHARED    = 1'b1,
  parameter int NUM_LINES = 3,
  parameter int ADDR_W    = 4,
  parameter int SLOW_DIV  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_raw,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  input  logic [3:0]           reg_wstrb,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int FW = FLD_W * NUM_LINES;

  initial begin
    a_r3_lane_fit: assert (NUM_LINES >= 1 && NUM_LINES <= 3 && SLOW_DIV >= 2);
  end

  logic                 slow_tick;
  logic [NUM_LINES-1:0] line_we;
  logic [FW-1:0]        line_wbyte;
  logic [FW-1:0]        line_rd;

  extirq_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (slow_tick)
  );

  extirq_regs #(.SHARED(SHARED), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .wstrb      (reg_wstrb),
    .line_rd    (line_rd),
    .line_we    (line_we),
    .line_wbyte (line_wbyte),
    .rdata      (reg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      extirq_line u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .raw_in    (irq_raw[i]),
        .wr_en     (line_we[i]),
        .wr_byte   (line_wbyte[i*8 +: 8]),
        .field_rd  (line_rd[i*8 +: 8]),
        .irq_out   (irq_out[i])
      );
    end
  endgenerate

endmodule

// File: tb/extirq_cond_test.sv
module extirq_cond_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [2:0]  raw_s, raw_p;
  logic [3:0]  addr_s, addr_p;
  logic        wr_s, wr_p;
  logic [31:0] wdata_s, wdata_p, rdata_s, rdata_p;
  logic [3:0]  strb_s, strb_p;
  logic [2:0]  irq_s, irq_p;

  int n_chk = 0;
  int n_bad = 0;

  extirq_cond #(.SHARED(1'b1), .SLOW_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .irq_raw(raw_s), .reg_addr(addr_s), .reg_wr(wr_s),
    .reg_wdata(wdata_s), .reg_wstrb(strb_s), .reg_rdata(rdata_s), .irq_out(irq_s));

  extirq_cond #(.SHARED(1'b0), .SLOW_DIV(DIV)) uut_sep (
    .clk(clk), .rst_n(rst_n), .irq_raw(raw_p), .reg_addr(addr_p), .reg_wr(wr_p),
    .reg_wdata(wdata_p), .reg_wstrb(strb_p), .reg_rdata(rdata_p), .irq_out(irq_p));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrs(input logic [3:0] a, input logic [3:0] st, input logic [31:0] d);
    @(negedge clk);
    addr_s = a; wdata_s = d; strb_s = st; wr_s = 1'b1;
    @(negedge clk);
    wr_s = 1'b0;
    #1;
  endtask

  task automatic wrp(input logic [3:0] a, input logic [3:0] st, input logic [7:0] d);
    @(negedge clk);
    addr_p = a; wdata_p = {24'hA5C3E1, d}; strb_p = st; wr_p = 1'b1;
    @(negedge clk);
    wr_p = 1'b0;
    #1;
  endtask

  // Shared layout: line i sits in byte lane 2-i
  task automatic set_line(input int i, input logic [7:0] b);
    wrs(4'd0, 4'b0001 << (2 - i), {24'h0, b} << ((2 - i) * 8));
  endtask

  function automatic logic [7:0] lane_of(input logic [31:0] w, input int i);
    return w[(2 - i) * 8 +: 8];
  endfunction

  // Expected read-back for a level line whose pin is held at 0
  function automatic logic [7:0] idle_field(input logic [7:0] v);
    logic req;
    req = v[5] & (v[7:6] == 2'b01);
    return {v[7:4], 3'b000, req};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] m [3];
    rst_n = 1'b0; raw_s = '0; raw_p = '0;
    addr_s = '0; addr_p = '0; wr_s = 1'b0; wr_p = 1'b0;
    wdata_s = '0; wdata_p = '0; strb_s = '0; strb_p = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    #1;

    // R1: reset state
    chk("R1 shared word", rdata_s, 32'h0);
    chk("R1 irq shared", {29'h0, irq_s}, 32'h0);
    for (int a = 0; a < 3; a++) begin
      addr_p = 4'(a); #1;
      chk("R1 split word", rdata_p, 32'h0);
    end
    chk("R1 irq split", {29'h0, irq_p}, 32'h0);

    // R2/R5: every byte value on every line of the split layout
    for (int i = 0; i < 3; i++) begin
      for (int v = 0; v < 256; v++) begin
        wrp(4'(i), 4'b0001, 8'(v));
        chk("R2 R5 split field", rdata_p, {24'h0, idle_field(8'(v))});
        chk("R6 idle level request", {31'h0, irq_p[i]}, {31'h0, idle_field(8'(v))[0]});
      end
    end
    // R5: strobe 0 off and out-of-range address are ignored
    wrp(4'd0, 4'b1110, 8'h40);
    chk("R5 strobe gate", rdata_p, {24'h0, idle_field(8'hFF)});
    wrp(4'd3, 4'b0001, 8'h20);
    chk("R5 high address reads zero", rdata_p, 32'h0);
    for (int a = 0; a < 3; a++) begin
      addr_p = 4'(a); #1;
      chk("R5 high address write ignored", rdata_p, {24'h0, idle_field(8'hFF)});
    end

    // R3/R4: all strobe patterns on the shared word
    for (int k = 0; k < 3; k++) m[k] = 8'h00;
    for (int st = 0; st < 16; st++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] d, exp;
        d = {8'(p * 8'h3B + st), 8'(st * 8'h29 + p), 8'(p * 8'h71 ^ st), 8'(st * 8'h17 + p * 5)};
        wrs(4'd0, 4'(st), d);
        for (int k = 0; k < 3; k++)
          if (st[2 - k]) m[k] = d[(2 - k) * 8 +: 8];
        exp = {8'h00, idle_field(m[0]), idle_field(m[1]), idle_field(m[2])};
        chk("R3 R4 shared word", rdata_s, exp);
      end
    end
    wrs(4'd1, 4'hF, 32'hFFFF_FFFF);
    chk("R3 other address reads zero", rdata_s, 32'h0);
    addr_s = 4'd0; #1;
    chk("R3 other address write ignored", rdata_s,
        {8'h00, idle_field(m[0]), idle_field(m[1]), idle_field(m[2])});

    // R6/R9: level types, both polarities, enabled and masked
    for (int i = 0; i < 3; i++)
      for (int t = 0; t < 2; t++)
        for (int e = 0; e < 2; e++)
          for (int v0 = 0; v0 < 2; v0++) begin
            logic exp0, exp1;
            wrs(4'd0, 4'hF, 32'h0);
            raw_s[i] = 1'(v0);
            step(3);
            set_line(i, {1'b0, 1'(t), 1'(e), 1'b1, 4'h0});
            exp0 = 1'(e) & (1'(v0) ^ 1'(t));
            exp1 = 1'(e) & (~1'(v0) ^ 1'(t));
            chk("R6 R9 level before", {31'h0, irq_s[i]}, {31'h0, exp0});
            chk("R6 request bit", {31'h0, lane_of(rdata_s, i)[0]}, {31'h0, exp0});
            raw_s[i] = ~1'(v0);
            step(1);
            chk("R6 level not early", {31'h0, irq_s[i]}, {31'h0, exp0});
            step(1);
            chk("R6 R9 level after two edges", {31'h0, irq_s[i]}, {31'h0, exp1});
          end

    // R7/R8/R9: edge types, pending and pulse
    for (int i = 0; i < 3; i++)
      for (int t = 2; t < 4; t++)
        for (int e = 0; e < 2; e++) begin
          logic idle;
          logic [7:0] b;
          idle = 1'(t & 1);
          b = {2'(t), 1'(e), 1'b1, 4'h0};
          wrs(4'd0, 4'hF, 32'h0);
          raw_s[i] = idle;
          step(3);
          set_line(i, b | 8'h01);
          chk("R7 pending clear at start", {31'h0, lane_of(rdata_s, i)[0]}, 32'h0);
          raw_s[i] = ~idle;
          step(2);
          chk("R7 pulse not early", {31'h0, irq_s[i]}, 32'h0);
          step(1);
          chk("R7 R9 pulse on third edge", {31'h0, irq_s[i]}, {31'h0, 1'(e)});
          chk("R7 R9 pending set", {31'h0, lane_of(rdata_s, i)[0]}, {31'h0, 1'(e)});
          step(1);
          chk("R7 pulse one cycle", {31'h0, irq_s[i]}, 32'h0);
          raw_s[i] = idle;
          step(4);
          chk("R7 opposite edge no pulse", {31'h0, irq_s[i]}, 32'h0);
          chk("R8 pending held", {31'h0, lane_of(rdata_s, i)[0]}, {31'h0, 1'(e)});
          set_line(i, b);
          chk("R8 write zero keeps pending", {31'h0, lane_of(rdata_s, i)[0]}, {31'h0, 1'(e)});
          set_line(i, b | 8'h01);
          chk("R8 write one clears", {31'h0, lane_of(rdata_s, i)[0]}, 32'h0);
        end

    // R10: slow sampling window
    wrs(4'd0, 4'hF, 32'h0);
    raw_s = '0;
    set_line(0, 8'b0010_0000);
    step(2 * DIV + 2);
    chk("R10 slow idle", {31'h0, irq_s[0]}, 32'h0);
    raw_s[0] = 1'b1;
    step(DIV);
    chk("R10 slow not before window", {31'h0, irq_s[0]}, 32'h0);
    step(DIV);
    chk("R10 slow within window", {31'h0, irq_s[0]}, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule